// File: doc/BRIEF.md
# Redundant Receive-Line Supervisor

This block sits between three redundant copies of a serial bus receive signal and the frame receiver of a bus node. It picks which copy feeds the receiver, watches the bus for stuck-dominant levels, for silence and for a lack of traffic aimed at this node, and moves to another copy when any of those watches expires. All watch periods are counted in pulses of a slow safety clock, and all are scaled from one base period of `BASE_T` ticks.

Once the node has gone quiet for long enough, the block latches a safety state and raises an interrupt pin. An external system uses that pin to put outputs into a fail-safe condition. Only an explicit exit strobe releases the safety state. Software writes the low nibble of a command register to choose the line policy and to enable or disable the supervision. The low nibble of a status byte reports the active line, whether the three copies agree, and whether the block is in safety.

Time-out periods in ticks: short = `BASE_T/16` consecutive ticks with the bus dominant; medium = `BASE_T/4` ticks with no coherent frame; long = `BASE_T` ticks with no frame addressed to the node; super-long = `4*BASE_T` ticks with no frame addressed to the node. A time-out reaches the outputs at the second clock edge after the tick edge that completes its period.

Top module: `line_guard`

## Requirements
- R1: After reset `sel_line` is 0, `safe_mode` and `int_pin` are 0, the line policy is automatic starting on line 0, and supervision is active.
- R2: A write with `cmd_we` decodes `cmd_lo[2:0]` at the next edge as follows. 000, 001 and 010 set automatic mode starting on line 0, 1 or 2. 100, 101 and 110 force line 0, 1 or 2. 111 forces line 0.
- R3: In automatic mode, an expiry of the short, medium or long time-out advances `sel_line` one step in the order 0, 1, 2, 0.
- R4: In forced mode, `sel_line` never changes on a time-out.
- R5: A write with `cmd_lo[2:0]` = 011 leaves the line and the line policy unchanged and updates only the supervision bit `cmd_lo[3]`.
- R6: `stat_lo[1:0]` equals `sel_line`. `stat_lo[2]` is 1 when all three receive lines were equal at the previous edge. `stat_lo[3]` equals `safe_mode`.
- R7: Until bus activity has been seen, `4*BASE_T` ticks without `frame_mine` set `safe_mode` when supervision is active. One tick fewer does not.
- R8: Seven level transitions on the selected line count as activity. After activity, `BASE_T` ticks without `frame_mine` set `safe_mode`. One tick fewer does not.
- R9: With `cmd_lo[3]` = 1 written, supervision is inhibited and safety is never entered. Instead, each `frame_mine` pulse gives a one-cycle pulse on `int_pin` one edge later.
- R10: While in safety, `int_pin` is 1. Safety persists through frames and commands. Only `exit_req` clears it, one edge later, and `exit_req` wins over a safety entry in the same cycle.
- R11: A command write in the same cycle as a pending rotation takes precedence: the written line is selected.
- R12: A dominant period that ends before `BASE_T/16` ticks does not move the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 3 | The three redundant receive copies |
| tick | input | 1 | One-cycle pulse per safety-clock period |
| bus_dominant | input | 1 | Receiver reports bus held dominant |
| frame_ok | input | 1 | Pulse: coherent frame seen on bus |
| frame_mine | input | 1 | Pulse: frame addressed this node |
| cmd_we | input | 1 | Command nibble write strobe |
| cmd_lo | input | 4 | Command nibble: [2:0] line policy, [3] supervision inhibit |
| exit_req | input | 1 | Safety exit strobe |
| sel_line | output | 2 | Index of line feeding the receiver |
| stat_lo | output | 4 | Status nibble: {safe, lines agree, sel_line} |
| safe_mode | output | 1 | Latched safety state |
| int_pin | output | 1 | Interrupt / safety pin |

## Verification
Two collisions are provoked in the same cycle. The first is a command write against a pending rotation: seven silent ticks, then an eighth, and the write is placed on the very cycle in which the medium time-out's expiry reaches the selector. The bench expects the written line, which differs from the rotated one. The second is an exit strobe placed on the cycle in which the super-long expiry would latch safety. The bench expects `safe_mode` and `int_pin` to stay low.

// File: rtl/lg_pkg.sv
package lg_pkg;

  typedef logic [1:0] line_t;

  localparam int unsigned NUM_LINES = 3;
  localparam int unsigned NUM_TO    = 4;
  localparam int unsigned TO_SHORT  = 0;
  localparam int unsigned TO_MED    = 1;
  localparam int unsigned TO_LONG   = 2;
  localparam int unsigned TO_SUPER  = 3;

  localparam logic [2:0] MODE_KEEP = 3'b011;

  function automatic line_t next_line(input line_t cur);
    return (cur == line_t'(NUM_LINES - 1)) ? line_t'(0) : line_t'(cur + 2'd1);
  endfunction

  function automatic line_t start_line(input logic [1:0] code);
    return (code == 2'b11) ? line_t'(0) : line_t'(code);
  endfunction

endpackage

// File: rtl/lg_timer.sv
module lg_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic clr,
  output logic fire
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          cnt  <= '0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lg_activity.sv
module lg_activity
  import lg_pkg::*;
#(
  parameter int unsigned EDGES = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] lines,
  input  line_t      sel,
  output logic       act
);
  localparam int unsigned CW = $clog2(EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  logic [CW-1:0] cnt;
  line_t         sel_d;
  logic          prev;
  logic          bit_now;

  always_comb begin
    case (sel)
      2'd1:    bit_now = lines[1];
      2'd2:    bit_now = lines[2];
      default: bit_now = lines[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      sel_d <= '0;
      prev  <= 1'b0;
      act   <= 1'b0;
    end else begin
      act   <= 1'b0;
      sel_d <= sel;
      prev  <= bit_now;
      if (sel != sel_d) begin
        cnt <= '0;
      end else if (bit_now != prev) begin
        if (cnt == LAST) begin
          cnt <= '0;
          act <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lg_selector.sv
module lg_selector
  import lg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [3:0] cmd_lo,
  input  logic       rotate,
  output line_t      sel,
  output logic [2:0] mode_q,
  output logic       inhibit
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel     <= '0;
      mode_q  <= '0;
      inhibit <= 1'b0;
    end else if (cmd_we) begin
      inhibit <= cmd_lo[3];
      if (cmd_lo[2:0] != MODE_KEEP) begin
        mode_q <= cmd_lo[2:0];
        sel    <= start_line(cmd_lo[1:0]);
      end
    end else if (rotate && !mode_q[2]) begin
      sel <= next_line(sel);
    end
  end
endmodule

// File: rtl/lg_safety.sv
module lg_safety (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic act,
  input  logic long_fire,
  input  logic super_fire,
  input  logic exit_req,
  input  logic frame_mine,
  output logic safe,
  output logic int_pin
);
  logic running;
  logic mine_q;
  logic enter;

  assign enter = !inhibit && ((running && long_fire) || (!running && super_fire));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      safe    <= 1'b0;
      running <= 1'b0;
      mine_q  <= 1'b0;
    end else begin
      mine_q <= frame_mine && inhibit;
      if (exit_req) begin
        safe    <= 1'b0;
        running <= 1'b0;
      end else begin
        if (enter) safe <= 1'b1;
        if (act)   running <= 1'b1;
      end
    end
  end

  assign int_pin = safe || mine_q;
endmodule

// File: rtl/line_guard.sv
module line_guard
  import lg_pkg::*;
#(
  parameter int unsigned BASE_T = 1024,
  parameter int unsigned EDGES  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rx_line,
  input  logic       tick,
  input  logic       bus_dominant,
  input  logic       frame_ok,
  input  logic       frame_mine,
  input  logic       cmd_we,
  input  logic [3:0] cmd_lo,
  input  logic       exit_req,
  output logic [1:0] sel_line,
  output logic [3:0] stat_lo,
  output logic       safe_mode,
  output logic       int_pin
);
  localparam int unsigned LIM_SHORT = (BASE_T / 16 > 0) ? BASE_T / 16 : 1;
  localparam int unsigned LIM_MED   = (BASE_T / 4 > 0) ? BASE_T / 4 : 1;
  localparam int unsigned LIM_LONG  = BASE_T;
  localparam int unsigned LIM_SUPER = 4 * BASE_T;
  localparam int unsigned LIMS [NUM_TO] = '{LIM_SHORT, LIM_MED, LIM_LONG, LIM_SUPER};

  logic [2:0]        rx_q;
  logic [NUM_TO-1:0] to_clr;
  logic [NUM_TO-1:0] to_fire;
  logic              rotate;
  logic              act;
  logic [2:0]        cmd_mode;
  logic              inhibit;
  logic              lines_agree;

  always_ff @(posedge clk) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_line;
  end

  assign lines_agree = (&rx_q) || !(|rx_q);

  assign to_clr[TO_SHORT] = !bus_dominant || exit_req;
  assign to_clr[TO_MED]   = frame_ok || exit_req;
  assign to_clr[TO_LONG]  = frame_mine || exit_req;
  assign to_clr[TO_SUPER] = frame_mine || exit_req;

  for (genvar g = 0; g < NUM_TO; g++) begin : g_to
    lg_timer #(.LIMIT(LIMS[g])) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .clr  (to_clr[g]),
      .fire (to_fire[g])
    );
  end

  assign rotate = to_fire[TO_SHORT] || to_fire[TO_MED] || to_fire[TO_LONG];

  lg_selector u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_we (cmd_we),
    .cmd_lo (cmd_lo),
    .rotate (rotate),
    .sel    (sel_line),
    .mode_q (cmd_mode),
    .inhibit(inhibit)
  );

  lg_activity #(.EDGES(EDGES)) u_act (
    .clk  (clk),
    .rst_n(rst_n),
    .lines(rx_q),
    .sel  (sel_line),
    .act  (act)
  );

  lg_safety u_safe (
    .clk       (clk),
    .rst_n     (rst_n),
    .inhibit   (inhibit),
    .act       (act),
    .long_fire (to_fire[TO_LONG]),
    .super_fire(to_fire[TO_SUPER]),
    .exit_req  (exit_req),
    .frame_mine(frame_mine),
    .safe      (safe_mode),
    .int_pin   (int_pin)
  );

  assign stat_lo = {safe_mode, lines_agree, sel_line};
endmodule

// File: rtl/line_guard_checker.sv
module line_guard_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] rx_line,
  input logic       cmd_we,
  input logic       exit_req,
  input logic [1:0] sel_line,
  input logic [3:0] stat_lo,
  input logic       safe_mode,
  input logic       int_pin,
  input logic [2:0] cmd_mode,
  input logic       inhibit
);
  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1: line index stays inside the three lines
  p_sel_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_line != 2'd3);

  // R4: forced policy holds the line unless software writes
  p_forced_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_mode[2] && !cmd_we) |=> $stable(sel_line));

  // R6: agreement flag reflects the previous edge's lines
  p_agree_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (stat_lo[2] == ($past(&rx_line) || $past(~|rx_line))));

  // R9: no entry while supervision is inhibited
  p_no_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !safe_mode) |=> !safe_mode);

  // R10: safety drives the pin, is sticky, and exits only on the strobe
  p_int_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    safe_mode |-> int_pin);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (safe_mode && !exit_req) |=> safe_mode);
  p_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |=> !safe_mode);
endmodule

bind line_guard line_guard_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_line  (rx_line),
  .cmd_we   (cmd_we),
  .exit_req (exit_req),
  .sel_line (sel_line),
  .stat_lo  (stat_lo),
  .safe_mode(safe_mode),
  .int_pin  (int_pin),
  .cmd_mode (cmd_mode),
  .inhibit  (inhibit)
);

// File: tb/line_guard_bench.sv
module line_guard_bench;
  localparam int unsigned BT  = 32;
  localparam int unsigned MED = BT / 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rx_line;
  logic       tick, bus_dominant, frame_ok, frame_mine, cmd_we, exit_req;
  logic [3:0] cmd_lo;
  logic [1:0] sel_line;
  logic [3:0] stat_lo;
  logic       safe_mode, int_pin;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  line_guard #(.BASE_T(BT)) u_line_guard (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick(tick),
    .bus_dominant(bus_dominant), .frame_ok(frame_ok), .frame_mine(frame_mine),
    .cmd_we(cmd_we), .cmd_lo(cmd_lo), .exit_req(exit_req),
    .sel_line(sel_line), .stat_lo(stat_lo), .safe_mode(safe_mode), .int_pin(int_pin)
  );

  // {cmd nibble, rx lines, expected line, expected agree}
  localparam logic [9:0] VEC [8] = '{
    {4'b0101, 3'b101, 2'd1, 1'b0},
    {4'b0110, 3'b000, 2'd2, 1'b1},
    {4'b0100, 3'b111, 2'd0, 1'b1},
    {4'b0001, 3'b010, 2'd1, 1'b0},
    {4'b0011, 3'b011, 2'd1, 1'b0},
    {4'b0010, 3'b111, 2'd2, 1'b1},
    {4'b0111, 3'b001, 2'd0, 1'b0},
    {4'b0000, 3'b000, 2'd0, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rx_line = '0; tick = 0; bus_dominant = 0; frame_ok = 0;
    frame_mine = 0; cmd_we = 0; cmd_lo = '0; exit_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_tick(input logic with_ok);
    @(negedge clk); tick = 1'b1; frame_ok = with_ok;
    @(negedge clk); tick = 1'b0; frame_ok = 1'b0;
  endtask

  task automatic ticks(input int n, input logic with_ok);
    for (int i = 0; i < n; i++) do_tick(with_ok);
    @(negedge clk);
  endtask

  task automatic write_cmd(input logic [3:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd_lo = c;
    @(negedge clk); cmd_we = 1'b0;
  endtask

  task automatic pulse_exit();
    @(negedge clk); exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 sel", sel_line, 0);
    check("R1 safe", safe_mode, 0);
    check("R1 int", int_pin, 0);
    check("R6 status at reset", stat_lo, 4'b0100);

    // R2 / R5 / R6 vector walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); cmd_we = 1'b1; cmd_lo = VEC[v][9:6]; rx_line = VEC[v][5:3];
      @(negedge clk); cmd_we = 1'b0;
      check("R2 decode sel", sel_line, VEC[v][2:1]);
      check("R6 stat line", stat_lo[1:0], VEC[v][2:1]);
      check("R6 agree", stat_lo[2], VEC[v][0]);
    end

    // R12 short dominant, then R3 short time-out
    do_reset();
    bus_dominant = 1'b1; do_tick(0); bus_dominant = 1'b0;
    repeat (2) @(negedge clk);
    check("R12 brief dominant", sel_line, 0);
    bus_dominant = 1'b1; ticks(2, 0); bus_dominant = 1'b0;
    check("R3 short time-out", sel_line, 1);

    // R3 medium time-out rotation with wrap
    do_reset();
    ticks(MED - 1, 0);
    check("R3 before medium", sel_line, 0);
    ticks(1, 0);
    check("R3 medium 0->1", sel_line, 1);
    ticks(MED, 0);
    check("R3 medium 1->2", sel_line, 2);
    ticks(MED, 0);
    check("R3 medium 2->0", sel_line, 0);

    // R4 forced, R5 transparent
    do_reset();
    write_cmd(4'b0101);
    ticks(2 * MED, 0);
    check("R4 forced hold", sel_line, 1);
    write_cmd(4'b1011);
    ticks(MED, 0);
    check("R5 keep line", sel_line, 1);

    // R11 write beats rotation
    do_reset();
    for (int i = 0; i < MED; i++) do_tick(0);
    cmd_we = 1'b1; cmd_lo = 4'b0010;
    @(negedge clk); cmd_we = 1'b0;
    check("R11 write wins", sel_line, 2);

    // R7 super-long entry and R10 stickiness/exit
    do_reset();
    ticks(4 * BT - 1, 0);
    check("R7 one tick short", safe_mode, 0);
    ticks(1, 0);
    check("R7 safe", safe_mode, 1);
    check("R10 int high", int_pin, 1);
    check("R6 stat safe", stat_lo[3], 1);
    @(negedge clk); frame_mine = 1'b1; @(negedge clk); frame_mine = 1'b0;
    write_cmd(4'b0001);
    check("R10 sticky", safe_mode, 1);
    pulse_exit();
    check("R10 exit safe", safe_mode, 0);
    check("R10 exit int", int_pin, 0);

    // R10 exit beats simultaneous entry
    do_reset();
    for (int i = 0; i < 4 * BT; i++) do_tick(0);
    exit_req = 1'b1;
    @(negedge clk); exit_req = 1'b0;
    check("R10 collision safe", safe_mode, 0);
    check("R10 collision int", int_pin, 0);

    // R8 activity then long time-out
    do_reset();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rx_line = ~rx_line;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    ticks(BT - 1, 1);
    check("R8 one tick short", safe_mode, 0);
    ticks(1, 1);
    check("R8 long entry", safe_mode, 1);

    // R9 inhibited supervision
    do_reset();
    write_cmd(4'b1000);
    ticks(4 * BT, 0);
    check("R9 no safety", safe_mode, 0);
    check("R9 int idle", int_pin, 0);
    @(negedge clk); frame_mine = 1'b1;
    @(negedge clk); frame_mine = 1'b0;
    check("R9 int pulse", int_pin, 1);
    @(negedge clk);
    check("R9 int pulse ends", int_pin, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule